// File: doc/BRIEF.md
# Script Block-Move Address Resolver

This unit sits in the instruction path of a script-driven SCSI DMA engine. When the sequencer has fetched the two dwords of a block-move instruction, it pulses `start_i`. It also presents the current script pointer, the table base pointer, the bus phase, three addressing-mode enables and the registers that can supply the upper half of a DMA address. The unit then works out three results: the transfer byte count, a full 64-bit DMA address, and the saved instruction address. It reads any extra words it needs, such as an indirect pointer target, a two-word table entry or a trailing high-address dword, through a single read port with a request/acknowledge handshake.

When decoding ends, the unit pulses `done_o` with all results valid. If the instruction's expected phase does not match the live bus phase, it pulses `phase_err_o` instead. When a table selector names no register, `sel_err_o` pulses alongside the result. Results stay on their outputs until the next instruction ends.

The controller runs through these states:
- S_IDLE waits for `start_i` and picks the path.
- S_IND waits for the indirect word.
- S_TBL_LO and S_TBL_HI wait for the two table words.
- S_DIR_HI waits for the trailing high dword.
- S_RESOLVE composes and registers the results.

Its transitions are:
- S_IDLE to S_IND when instruction bit 29 is set.
- S_IDLE to S_TBL_LO when bit 28 is set and bit 29 is clear.
- S_IDLE to S_DIR_HI when neither bit is set and `dir64_i` is high.
- S_IDLE to S_RESOLVE for a plain direct move.
- S_TBL_LO to S_TBL_HI on the first acknowledge.
- S_IND, S_TBL_HI or S_DIR_HI to S_RESOLVE on the last acknowledge.
- S_RESOLVE to S_IDLE always.

Top module: `bmv_addr_unit`

## Requirements
- R1: Outside table mode, `byte_cnt_o` and `rem_cnt_o` both equal bits 23:0 of `insn_i`, and in direct mode the low address equals `ptr_i`.
- R2: With `insn_i` bit 29 set, whatever bit 28 is, exactly one word is read at `ptr_i` and becomes the low 32 address bits. No trailing dword is fetched even when `dir64_i` is high.
- R3: With bit 28 set and bit 29 clear, two words are read, at `tbl_base_i` plus the sign-extended `ptr_i[23:0]`, then 4 bytes above. The count is bits 23:0 of the first word and the low address is the second word.
- R4: In table mode with `wide40_i` high, address bits 63:32 are bits 31:24 of the first table word, zero-extended. `wide40_i` takes precedence over `tbl64_i`.
- R5: In table mode with `tbl64_i` high and `wide40_i` low, bits 28:24 of the first table word select the upper half as follows:
  - 0..15 select `scratch_i[sel]`.
  - 16 selects `rd_sel_i`.
  - 17 selects `wr_sel_i`.
  - 18 selects `fetch_stat_i`.
  - 19 selects `dyn_sel_i`.
  - 20 selects `src_hi_i`.
  - 21 selects `dst_hi_i`.
- R6: A selector above 21 pulses `sel_err_o` for one cycle together with the result, and address bits 63:32 are zero.
- R7: In direct mode with `dir64_i` high, one word is read at `script_ptr_i`. It becomes `dst_hi_o`, and `script_ptr_o` is `script_ptr_i + 4`. Otherwise `script_ptr_o` equals `script_ptr_i` and `dst_hi_o` equals `dst_hi_i`.
- R8: `saved_pc_o` is always `script_ptr_i - 8`, which equals `script_ptr_o - 12` after a trailing-dword fetch.
- R9: When neither `wide40_i` nor `tbl64_i` is high, address bits 63:32 are chosen in this order:
  - the resolved high-dword value if it is nonzero;
  - otherwise `src_hi_i` if it is nonzero;
  - otherwise zero.
  With either enable high outside table mode, the upper half is zero.
- R10: If `insn_i[26:24]` differs from `phase_i`, `phase_err_o` pulses in place of `done_o`.
- R11: Only one read is outstanding at a time, and `rd_req_o` and `rd_addr_o` hold steady until the cycle `rd_ack_i` is seen. The reads occur in the order listed above.
- R12: `done_o` or `phase_err_o` is a one-cycle pulse. It comes 2 cycles after `start_i` when no read is needed, otherwise 3 cycles after the last acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin decoding (honoured in S_IDLE) |
| insn_i | input | 32 | First instruction dword |
| ptr_i | input | 32 | Second instruction dword |
| script_ptr_i | input | 32 | Script pointer past the two dwords |
| tbl_base_i | input | 32 | Table base pointer |
| phase_i | input | 3 | Current bus phase |
| wide40_i | input | 1 | 40-bit table addressing enable |
| tbl64_i | input | 1 | Selector-based 64-bit table enable |
| dir64_i | input | 1 | Trailing high-dword enable |
| scratch_i | input | 16x32 | Scratch registers for selectors 0..15 |
| rd_sel_i | input | 32 | Selector 16 source |
| wr_sel_i | input | 32 | Selector 17 source |
| fetch_stat_i | input | 32 | Selector 18 source |
| dyn_sel_i | input | 32 | Selector 19 source |
| src_hi_i | input | 32 | Source high-address register |
| dst_hi_i | input | 32 | Destination high-address register |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Memory read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 32 | Read data |
| done_o | output | 1 | Result-valid pulse |
| phase_err_o | output | 1 | Phase mismatch pulse |
| sel_err_o | output | 1 | Illegal selector pulse |
| byte_cnt_o | output | 24 | Byte count |
| rem_cnt_o | output | 24 | Remaining-byte counter load value |
| dma_addr_o | output | 64 | Composed DMA address |
| saved_pc_o | output | 32 | Saved instruction address |
| script_ptr_o | output | 32 | Updated script pointer |
| dst_hi_o | output | 32 | Updated destination high-address register |

## Verification
A state held in the wrong controller state, or a wrong path choice, appears at once on the read port. It shows as an extra, missing or misaddressed request, which the bench's expected-address queue catches at the acknowledge. A stale or misrouted latched word, such as a table word or trailing dword, appears only at the result pulse. The pulse lands at a cycle the bench predicts exactly from the last acknowledge. Selector, priority and phase errors therefore show up within three cycles of the final read.

// File: rtl/bmv_pkg.sv
package bmv_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 24;
    localparam int SEL_W   = 5;
    localparam int SEL_LSB = 24;
    localparam int PH_W    = 3;
    localparam int PH_LSB  = 24;
    localparam int IND_BIT = 29;
    localparam int TBL_BIT = 28;
    localparam int HI8_W   = 8;
    localparam int N_FIXED = 6;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_IND     = 3'd1,
        S_TBL_LO  = 3'd2,
        S_TBL_HI  = 3'd3,
        S_DIR_HI  = 3'd4,
        S_RESOLVE = 3'd5
    } bmv_state_t;
endpackage

// File: rtl/bmv_fetch.sv
module bmv_fetch
    import bmv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [WORD_W-1:0] go_addr_i,
    output logic              rd_req_o,
    output logic [WORD_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              got_o,
    output logic [WORD_W-1:0] got_data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_req_o   <= 1'b0;
            rd_addr_o  <= '0;
            got_o      <= 1'b0;
            got_data_o <= '0;
        end else begin
            got_o <= 1'b0;
            if (go_i) begin
                rd_req_o  <= 1'b1;
                rd_addr_o <= go_addr_i;
            end else if (rd_req_o && rd_ack_i) begin
                rd_req_o   <= 1'b0;
                got_o      <= 1'b1;
                got_data_o <= rd_data_i;
            end
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

    // R11
    one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !go_i);
endmodule

// File: rtl/bmv_hisel.sv
module bmv_hisel
    import bmv_pkg::*;
#(
    parameter int N_SCRATCH = 16
) (
    input  logic [SEL_W-1:0]                 sel_i,
    input  logic [N_SCRATCH-1:0][WORD_W-1:0] scratch_i,
    input  logic [WORD_W-1:0]                rd_sel_i,
    input  logic [WORD_W-1:0]                wr_sel_i,
    input  logic [WORD_W-1:0]                fetch_stat_i,
    input  logic [WORD_W-1:0]                dyn_sel_i,
    input  logic [WORD_W-1:0]                src_hi_i,
    input  logic [WORD_W-1:0]                dst_hi_i,
    output logic [WORD_W-1:0]                val_o,
    output logic                             illegal_o
);
    localparam int NSRC = N_SCRATCH + N_FIXED;

    logic [WORD_W-1:0] pool [NSRC];

    for (genvar g = 0; g < N_SCRATCH; g++) begin : g_scr
        assign pool[g] = scratch_i[g];
    end
    assign pool[N_SCRATCH + 0] = rd_sel_i;
    assign pool[N_SCRATCH + 1] = wr_sel_i;
    assign pool[N_SCRATCH + 2] = fetch_stat_i;
    assign pool[N_SCRATCH + 3] = dyn_sel_i;
    assign pool[N_SCRATCH + 4] = src_hi_i;
    assign pool[N_SCRATCH + 5] = dst_hi_i;

    always_comb begin
        val_o     = '0;
        illegal_o = 1'b1;
        for (int k = 0; k < NSRC; k++) begin
            if (sel_i == k[SEL_W-1:0]) begin
                val_o     = pool[k];
                illegal_o = 1'b0;
            end
        end
    end

    // R5
    always_comb begin
        legal_range_chk: assert (!(sel_i < SEL_W'(N_SCRATCH) && illegal_o));
    end
endmodule

// File: rtl/bmv_compose.sv
module bmv_compose
    import bmv_pkg::*;
(
    input  logic                  use_stored_i,
    input  logic [WORD_W-1:0]     stored_i,
    input  logic [WORD_W-1:0]     dst_hi_i,
    input  logic [WORD_W-1:0]     src_hi_i,
    input  logic [WORD_W-1:0]     lo_i,
    output logic [2*WORD_W-1:0]   addr_o
);
    logic [WORD_W-1:0] hi;

    always_comb begin
        if (use_stored_i)
            hi = stored_i;
        else if (dst_hi_i != '0)
            hi = dst_hi_i;
        else if (src_hi_i != '0)
            hi = src_hi_i;
        else
            hi = '0;
        addr_o = {hi, lo_i};
    end
endmodule

// File: rtl/bmv_addr_unit.sv
module bmv_addr_unit
    import bmv_pkg::*;
#(
    parameter int N_SCRATCH = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_i,
    input  logic [WORD_W-1:0]                insn_i,
    input  logic [WORD_W-1:0]                ptr_i,
    input  logic [WORD_W-1:0]                script_ptr_i,
    input  logic [WORD_W-1:0]                tbl_base_i,
    input  logic [PH_W-1:0]                  phase_i,
    input  logic                             wide40_i,
    input  logic                             tbl64_i,
    input  logic                             dir64_i,
    input  logic [N_SCRATCH-1:0][WORD_W-1:0] scratch_i,
    input  logic [WORD_W-1:0]                rd_sel_i,
    input  logic [WORD_W-1:0]                wr_sel_i,
    input  logic [WORD_W-1:0]                fetch_stat_i,
    input  logic [WORD_W-1:0]                dyn_sel_i,
    input  logic [WORD_W-1:0]                src_hi_i,
    input  logic [WORD_W-1:0]                dst_hi_i,
    output logic                             rd_req_o,
    output logic [WORD_W-1:0]                rd_addr_o,
    input  logic                             rd_ack_i,
    input  logic [WORD_W-1:0]                rd_data_i,
    output logic                             done_o,
    output logic                             phase_err_o,
    output logic                             sel_err_o,
    output logic [CNT_W-1:0]                 byte_cnt_o,
    output logic [CNT_W-1:0]                 rem_cnt_o,
    output logic [2*WORD_W-1:0]              dma_addr_o,
    output logic [WORD_W-1:0]                saved_pc_o,
    output logic [WORD_W-1:0]                script_ptr_o,
    output logic [WORD_W-1:0]                dst_hi_o
);
    localparam int STEP    = WORD_W / 8;
    localparam int EXT_W   = WORD_W - CNT_W;
    localparam int PC_BACK = 2 * STEP;

    bmv_state_t state_q, state_d;

    logic [WORD_W-1:0] insn_q, lo_q, tw0_q, dhi_q, base_q, sp_q;
    logic              w40_q, t64_q, tbl_q, dir_q;
    logic              go;
    logic [WORD_W-1:0] go_addr;
    logic              got;
    logic [WORD_W-1:0] got_data;
    logic [WORD_W-1:0] tbl_addr_c;

    assign tbl_addr_c = tbl_base_i + {{EXT_W{ptr_i[CNT_W-1]}}, ptr_i[CNT_W-1:0]};

    bmv_fetch u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .go_addr_i  (go_addr),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o),
        .rd_ack_i   (rd_ack_i),
        .rd_data_i  (rd_data_i),
        .got_o      (got),
        .got_data_o (got_data)
    );

    // next state and read launch
    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        go_addr = '0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    if (insn_i[IND_BIT]) begin
                        state_d = S_IND;
                        go      = 1'b1;
                        go_addr = ptr_i;
                    end else if (insn_i[TBL_BIT]) begin
                        state_d = S_TBL_LO;
                        go      = 1'b1;
                        go_addr = tbl_addr_c;
                    end else if (dir64_i) begin
                        state_d = S_DIR_HI;
                        go      = 1'b1;
                        go_addr = script_ptr_i;
                    end else begin
                        state_d = S_RESOLVE;
                    end
                end
            end
            S_IND:    if (got) state_d = S_RESOLVE;
            S_TBL_LO: begin
                if (got) begin
                    state_d = S_TBL_HI;
                    go      = 1'b1;
                    go_addr = base_q + WORD_W'(STEP);
                end
            end
            S_TBL_HI:  if (got) state_d = S_RESOLVE;
            S_DIR_HI:  if (got) state_d = S_RESOLVE;
            S_RESOLVE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insn_q <= '0;
            lo_q   <= '0;
            tw0_q  <= '0;
            dhi_q  <= '0;
            base_q <= '0;
            sp_q   <= '0;
            w40_q  <= 1'b0;
            t64_q  <= 1'b0;
            tbl_q  <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                insn_q <= insn_i;
                lo_q   <= ptr_i;
                tw0_q  <= '0;
                dhi_q  <= dst_hi_i;
                base_q <= tbl_addr_c;
                sp_q   <= script_ptr_i;
                w40_q  <= wide40_i;
                t64_q  <= tbl64_i;
                tbl_q  <= !insn_i[IND_BIT] && insn_i[TBL_BIT];
                dir_q  <= !insn_i[IND_BIT] && !insn_i[TBL_BIT] && dir64_i;
            end
            if (got) begin
                unique case (state_q)
                    S_IND:    lo_q  <= got_data;
                    S_TBL_LO: tw0_q <= got_data;
                    S_TBL_HI: lo_q  <= got_data;
                    S_DIR_HI: dhi_q <= got_data;
                    default:  ;
                endcase
            end
        end
    end

    // resolve stage
    logic [WORD_W-1:0]   sel_val;
    logic                sel_bad;
    logic [WORD_W-1:0]   stored_c;
    logic                bad_c;
    logic [2*WORD_W-1:0] addr_c;
    logic [CNT_W-1:0]    cnt_c;

    bmv_hisel #(.N_SCRATCH(N_SCRATCH)) u_hisel (
        .sel_i        (tw0_q[SEL_LSB +: SEL_W]),
        .scratch_i    (scratch_i),
        .rd_sel_i     (rd_sel_i),
        .wr_sel_i     (wr_sel_i),
        .fetch_stat_i (fetch_stat_i),
        .dyn_sel_i    (dyn_sel_i),
        .src_hi_i     (src_hi_i),
        .dst_hi_i     (dhi_q),
        .val_o        (sel_val),
        .illegal_o    (sel_bad)
    );

    always_comb begin
        stored_c = '0;
        bad_c    = 1'b0;
        if (tbl_q) begin
            if (w40_q) begin
                stored_c = {{(WORD_W-HI8_W){1'b0}}, tw0_q[WORD_W-1 -: HI8_W]};
            end else if (t64_q) begin
                if (sel_bad) bad_c    = 1'b1;
                else         stored_c = sel_val;
            end
        end
        cnt_c = tbl_q ? tw0_q[CNT_W-1:0] : insn_q[CNT_W-1:0];
    end

    bmv_compose u_compose (
        .use_stored_i (w40_q || t64_q),
        .stored_i     (stored_c),
        .dst_hi_i     (dhi_q),
        .src_hi_i     (src_hi_i),
        .lo_i         (lo_q),
        .addr_o       (addr_c)
    );

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o       <= 1'b0;
            phase_err_o  <= 1'b0;
            sel_err_o    <= 1'b0;
            byte_cnt_o   <= '0;
            rem_cnt_o    <= '0;
            dma_addr_o   <= '0;
            saved_pc_o   <= '0;
            script_ptr_o <= '0;
            dst_hi_o     <= '0;
        end else begin
            done_o      <= 1'b0;
            phase_err_o <= 1'b0;
            sel_err_o   <= 1'b0;
            if (state_q == S_RESOLVE) begin
                if (insn_q[PH_LSB +: PH_W] == phase_i) done_o <= 1'b1;
                else                                   phase_err_o <= 1'b1;
                sel_err_o    <= bad_c;
                byte_cnt_o   <= cnt_c;
                rem_cnt_o    <= cnt_c;
                dma_addr_o   <= addr_c;
                saved_pc_o   <= sp_q - WORD_W'(PC_BACK);
                script_ptr_o <= dir_q ? sp_q + WORD_W'(STEP) : sp_q;
                dst_hi_o     <= dhi_q;
            end
        end
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && phase_err_o));

    // R6
    sel_err_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err_o |-> dma_addr_o[2*WORD_W-1:WORD_W] == '0);

    // R11
    req_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (state_q inside {S_IND, S_TBL_LO, S_TBL_HI, S_DIR_HI}));

    // R12
    result_after_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || phase_err_o) |-> $past(state_q) == S_RESOLVE);
endmodule

// File: tb/test_bmv_addr_unit.sv
module test_bmv_addr_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        start_i = 0;
    logic [31:0] insn_i = 0, ptr_i = 0, script_ptr_i = 0, tbl_base_i = 0;
    logic [2:0]  phase_i = 0;
    logic        wide40_i = 0, tbl64_i = 0, dir64_i = 0;
    logic [15:0][31:0] scratch_i;
    logic [31:0] rd_sel_i = 32'h1111_0010, wr_sel_i = 32'h1111_0011;
    logic [31:0] fetch_stat_i = 32'h1111_0012, dyn_sel_i = 32'h1111_0013;
    logic [31:0] src_hi_i = 0, dst_hi_i = 0;
    logic        rd_req_o, rd_ack_i;
    logic [31:0] rd_addr_o, rd_data_i;
    logic        done_o, phase_err_o, sel_err_o;
    logic [23:0] byte_cnt_o, rem_cnt_o;
    logic [63:0] dma_addr_o;
    logic [31:0] saved_pc_o, script_ptr_o, dst_hi_o;

    bmv_addr_unit i_bmv_addr_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i), .ptr_i(ptr_i),
        .script_ptr_i(script_ptr_i), .tbl_base_i(tbl_base_i), .phase_i(phase_i),
        .wide40_i(wide40_i), .tbl64_i(tbl64_i), .dir64_i(dir64_i), .scratch_i(scratch_i),
        .rd_sel_i(rd_sel_i), .wr_sel_i(wr_sel_i), .fetch_stat_i(fetch_stat_i),
        .dyn_sel_i(dyn_sel_i), .src_hi_i(src_hi_i), .dst_hi_i(dst_hi_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .done_o(done_o), .phase_err_o(phase_err_o), .sel_err_o(sel_err_o),
        .byte_cnt_o(byte_cnt_o), .rem_cnt_o(rem_cnt_o), .dma_addr_o(dma_addr_o),
        .saved_pc_o(saved_pc_o), .script_ptr_o(script_ptr_o), .dst_hi_o(dst_hi_o)
    );

    int total = 0, fails = 0, cyc = 0, last_ack = 0, lat_sel = 0;
    string cur_tag = "R11";
    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_rd [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder with programmable latency
    initial begin
        int cnt;
        logic [31:0] a0;
        cnt = -1; a0 = 0;
        rd_ack_i = 0; rd_data_i = 0;
        forever begin
            @(negedge clk);
            rd_ack_i = 0;
            if (rd_req_o) begin
                if (cnt < 0) begin cnt = lat_sel; a0 = rd_addr_o; end
                else chk("R11", {32'd0, rd_addr_o}, {32'd0, a0}, "address held");
                if (cnt == 0) begin
                    if (exp_rd.size() == 0) chk(cur_tag, 64'd1, 64'd0, "unexpected read");
                    else chk(cur_tag, {32'd0, rd_addr_o}, {32'd0, exp_rd.pop_front()}, "read address");
                    rd_data_i = mem.exists(rd_addr_o) ? mem[rd_addr_o] : 32'hDEAD_BEEF;
                    rd_ack_i = 1; last_ack = cyc; cnt = -1;
                end else cnt--;
            end
        end
    end

    function automatic logic [31:0] sel_src(input int s);
        case (s)
            16: return rd_sel_i;
            17: return wr_sel_i;
            18: return fetch_stat_i;
            19: return dyn_sel_i;
            20: return src_hi_i;
            21: return dst_hi_i;
            default: return scratch_i[s];
        endcase
    endfunction

    task automatic run_op(input logic [31:0] insn, input logic [31:0] ptr, input logic [31:0] sp,
                          input logic [31:0] base, input logic [31:0] dhi, input logic [31:0] shi,
                          input logic w40, input logic t64, input logic d64,
                          input logic [2:0] ph, input int lat, input string tag);
        bit ind, tbl, dir, serr, ph_ok;
        logic [31:0] taddr, lo, stored, dv, hi;
        logic [23:0] cnt;
        int nrd, c0, k, want;
        ind = insn[29]; tbl = !insn[29] && insn[28]; dir = !ind && !tbl && d64;
        taddr = base + {{8{ptr[23]}}, ptr[23:0]};
        nrd = 0;
        cur_tag = tag;
        if (ind) begin exp_rd.push_back(ptr); nrd = 1; end
        else if (tbl) begin exp_rd.push_back(taddr); exp_rd.push_back(taddr + 4); nrd = 2; end
        else if (dir) begin exp_rd.push_back(sp); nrd = 1; end
        cnt = tbl ? mem[taddr][23:0] : insn[23:0];
        lo = ind ? mem[ptr] : (tbl ? mem[taddr + 4] : ptr);
        stored = 0; serr = 0;
        dst_hi_i = dhi; src_hi_i = shi;
        if (tbl && w40) stored = {24'd0, mem[taddr][31:24]};
        else if (tbl && t64) begin
            if (int'(mem[taddr][28:24]) <= 21) stored = sel_src(int'(mem[taddr][28:24]));
            else serr = 1;
        end
        dv = dir ? mem[sp] : dhi;
        if (w40 || t64) hi = stored;
        else if (dv != 0) hi = dv;
        else if (shi != 0) hi = shi;
        else hi = 0;
        ph_ok = (insn[26:24] == ph);

        @(negedge clk);
        insn_i = insn; ptr_i = ptr; script_ptr_i = sp; tbl_base_i = base;
        wide40_i = w40; tbl64_i = t64; dir64_i = d64; phase_i = ph; lat_sel = lat;
        start_i = 1; c0 = cyc;
        @(negedge clk);
        start_i = 0;
        k = 0;
        while (!(done_o || phase_err_o) && k < 60) begin @(negedge clk); k++; end
        want = (nrd == 0) ? c0 + 2 : last_ack + 3;
        chk("R12", 64'(cyc), 64'(want), {tag, " result cycle"});
        chk("R10", {63'd0, done_o}, {63'd0, ph_ok}, {tag, " done"});
        chk("R10", {63'd0, phase_err_o}, {63'd0, !ph_ok}, {tag, " phase error"});
        if (ph_ok) begin
            chk(tag, 64'(byte_cnt_o), 64'(cnt), "byte count");
            chk(tag, 64'(rem_cnt_o), 64'(cnt), "remaining count");
            chk(tag, dma_addr_o, {hi, lo}, "dma address");
            chk(serr ? "R6" : tag, {63'd0, sel_err_o}, {63'd0, serr}, "selector error");
            chk("R8", 64'(saved_pc_o), 64'(sp - 32'd8), "saved pc");
            chk("R7", 64'(script_ptr_o), 64'(dir ? sp + 32'd4 : sp), "script pointer");
            chk("R7", 64'(dst_hi_o), 64'(dv), "dst hi");
        end
        @(negedge clk);
        chk("R12", {62'd0, done_o, phase_err_o}, 64'd0, {tag, " pulse width"});
        chk("R11", 64'(exp_rd.size()), 64'd0, {tag, " reads consumed"});
        exp_rd.delete();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) scratch_i[i] = 32'h5C00_0000 + 32'(i * 32'h111);
        repeat (4) @(negedge clk);
        chk("R12", {61'd0, done_o, phase_err_o, sel_err_o}, 64'd0, "reset pulses");
        chk("R11", {63'd0, rd_req_o}, 64'd0, "reset request");
        rst_n = 1;
        @(negedge clk);
        chk("R11", {63'd0, rd_req_o}, 64'd0, "idle request");

        // R1 R9: plain direct, all zero high
        run_op(32'h0100_0123, 32'h1000_2000, 32'h0000_0408, 0, 0, 0, 0, 0, 0, 3'd1, 0, "R1");
        // R9: source high used
        run_op(32'h0200_0040, 32'h0000_A000, 32'h0000_0510, 0, 0, 32'h0000_0077, 0, 0, 0, 3'd2, 0, "R9");
        // R9: destination high beats source
        run_op(32'h0200_0041, 32'h0000_A004, 32'h0000_0520, 0, 32'h0000_0099, 32'h0000_0077, 0, 0, 0, 3'd2, 0, "R9");
        // R9: 40-bit enable outside table gives zero high
        run_op(32'h0200_0042, 32'h0000_A008, 32'h0000_0530, 0, 32'h0000_0099, 32'h0000_0077, 1, 0, 0, 3'd2, 0, "R9");
        // R7: trailing dword
        mem[32'h0000_0600] = 32'h0000_00AB;
        run_op(32'h0300_0100, 32'h0000_B000, 32'h0000_0600, 0, 32'h0000_0001, 0, 0, 0, 1, 3'd3, 2, "R7");
        // R7 R9: trailing dword zero, source high fallback
        mem[32'h0000_0700] = 32'h0;
        run_op(32'h0300_0101, 32'h0000_B100, 32'h0000_0700, 0, 32'h0000_0005, 32'h0000_0033, 0, 0, 1, 3'd3, 1, "R7");
        // R2: indirect, trailing dword enable ignored
        mem[32'h0000_8000] = 32'hCAFE_0000;
        run_op(32'h2400_0200, 32'h0000_8000, 32'h0000_0800, 0, 0, 0, 0, 0, 1, 3'd4, 1, "R2");
        // R2: bit 29 beats bit 28
        mem[32'h0000_8100] = 32'hCAFE_0100;
        run_op(32'h3400_0201, 32'h0000_8100, 32'h0000_0810, 32'h0000_9000, 0, 0, 0, 0, 0, 3'd4, 0, "R2");
        // R3: table with negative offset, plain 32-bit
        mem[32'h0000_8FF0] = 32'h7F00_1234;
        mem[32'h0000_8FF4] = 32'hBEEF_0000;
        run_op(32'h1500_0000, 32'h00FF_FFF0, 32'h0000_0900, 32'h0000_9000, 0, 0, 0, 0, 0, 3'd5, 3, "R3");
        // R4: 40-bit table, beats 64-bit table enable
        mem[32'h0000_9010] = 32'h5A00_0456;
        mem[32'h0000_9014] = 32'h0000_C000;
        run_op(32'h1600_0000, 32'h0000_0010, 32'h0000_0A00, 32'h0000_9000, 32'h0000_00EE, 0, 1, 1, 0, 3'd6, 1, "R4");
        // R5: every legal selector
        for (int s = 0; s < 22; s++) begin
            mem[32'h0000_A000] = {3'b0, 5'(s), 24'h000040 + 24'(s)};
            mem[32'h0000_A004] = 32'h0000_D000 + 32'(s);
            run_op(32'h1700_0000, 32'h0000_0000, 32'h0000_0B00, 32'h0000_A000,
                   32'h0000_0D0D, 32'h0000_0E0E, 0, 1, 0, 3'd7, s % 3, "R5");
        end
        // R6: illegal selectors give zero high even with nonzero registers
        for (int s = 22; s < 32; s += 9) begin
            mem[32'h0000_A100] = {3'b111, 5'(s), 24'h000100};
            mem[32'h0000_A104] = 32'h0000_E000;
            run_op(32'h1000_0000, 32'h0000_0100, 32'h0000_0C00, 32'h0000_A000,
                   32'h0000_0D0D, 32'h0000_0E0E, 0, 1, 0, 3'd0, 1, "R6");
        end
        // R10: phase mismatch
        run_op(32'h0100_0050, 32'h0000_F000, 32'h0000_0D00, 0, 0, 0, 0, 0, 0, 3'd6, 0, "R10");
        mem[32'h0000_0E00] = 32'h0000_0042;
        run_op(32'h0500_0051, 32'h0000_F100, 32'h0000_0E00, 0, 0, 0, 0, 0, 1, 3'd2, 2, "R10");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule